// File: doc/BRIEF.md
# Receive-Side RTS Pacer with Trigger Hysteresis

This block decides when the local receiver asks the far end to pause. It watches the occupancy of a 16-entry receive FIFO and drives an active-low request-to-send line. Software picks one of four receive trigger levels: 1, 4, 8 or 14 bytes. A receive-level interrupt fires at that trigger level. The pause itself does not switch at a single threshold. The line goes inactive only when the FIFO reaches the next table entry above the chosen level. It goes active again only after the FIFO drains to the next entry below. This gap stops the line from chattering when the reader and writer run at similar rates.

Automatic pacing runs when its enable is set. It starts only once the modem-control RTS bit is written to 1. With automatic pacing off, the line simply follows the inverse of that bit. The FIFO keeps accepting data while the line is inactive, so the surrounding receiver fills it until it is full. Any low-to-high change on the line can set a status flag and raise an interrupt request. This happens only when both the RTS interrupt enable and the enhanced-function enable are set. A read of the interrupt status clears the flag.

Top module: `rx_rts_pacer`

## Requirements
- R1: While reset is held, at the first clock edge and after, rtsN is 1 and rxLevelIrq, rtsIrq and rtsStatus are 0.
- R2: With autoRtsEn at 0, rtsN equals the inverse of mcrRts one clock after it is sampled.
- R3: With autoRtsEn at 1, rtsN is 1 while mcrRts is 0. The clock after mcrRts is sampled at 1 from that idle condition, rtsN becomes 0 (pacing started).
- R4: trigSel values 0, 1, 2 and 3 select trigger levels 1, 4, 8 and 14. rxLevelIrq is 1 one clock after fifoCount is sampled at or above the selected level, and 0 one clock after it is below.
- R5: While pacing is active with rtsN at 0, rtsN becomes 1 one clock after fifoCount reaches the next higher table entry. For trigSel 0, 1, 2 and 3 that entry is 4, 8, 14 and 16 (full).
- R6: While paused with rtsN at 1, rtsN becomes 0 one clock after fifoCount falls to or below the next lower table entry. For trigSel 0, 1, 2 and 3 that entry is 0, 1, 4 and 8.
- R7: While pacing, a fifoCount strictly between the lower and upper entries leaves rtsN unchanged.
- R8: A clock edge at which rtsN rises sets rtsStatus to 1 when rtsIntEn and enhancedEn were both 1 before that edge.
- R9: A rise of rtsN while rtsIntEn or enhancedEn is 0 leaves rtsStatus unchanged.
- R10: isrRead sampled at 1 clears rtsStatus on the next clock. A rise that sets the flag at the same edge takes priority.
- R11: rtsIrq is 1 exactly when rtsStatus, rtsIntEn and enhancedEn are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| fifoCount | input | 5 | Receive FIFO occupancy, 0 to 16 |
| trigSel | input | 2 | Receive trigger-level select |
| autoRtsEn | input | 1 | Automatic RTS pacing enable |
| enhancedEn | input | 1 | Enhanced-function enable (gates the RTS interrupt) |
| rtsIntEn | input | 1 | RTS interrupt enable |
| mcrRts | input | 1 | Modem-control RTS bit |
| isrRead | input | 1 | Interrupt-status read strobe, clears the RTS flag |
| rtsN | output | 1 | Request-to-send, active low |
| rxLevelIrq | output | 1 | Receive FIFO at or above trigger level |
| rtsIrq | output | 1 | RTS change interrupt request |
| rtsStatus | output | 1 | RTS change status flag |

## Verification
Inputs are sampled at a rising edge, and rtsN, rxLevelIrq and rtsStatus all show the result right after that same edge. Each of them lags the stimulus by exactly one clock. rtsIrq is a gate on the registered flag, so it changes at once when an enable changes. The bench drives inputs just after the falling edge. A behavioural model advances on each rising edge, and all four outputs are compared with it at the following falling edge. Every comparison therefore falls in the cycle where the one-register delay says the new value has to be present.

// File: rtl/rts_pacer_pkg.sv
package rts_pacer_pkg;

  typedef enum logic [1:0] {
    RTS_IDLE   = 2'd0,
    RTS_ACTIVE = 2'd1,
    RTS_PAUSED = 2'd2
  } rtsState_e;

  // Level comparison strobes from the datapath to the control
  typedef struct packed {
    logic atTrigger;
    logic atUpper;
    logic atLower;
  } levelFlags_t;

endpackage

// File: rtl/rts_level_cmp.sv
module rts_level_cmp
  import rts_pacer_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TRIG0 = 1,
  parameter int TRIG1 = 4,
  parameter int TRIG2 = 8,
  parameter int TRIG3 = 14,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic [1:0]       trigSel,
  output levelFlags_t      flags,
  output logic [CNT_W-1:0] trigLevel,
  output logic [CNT_W-1:0] upperLevel,
  output logic [CNT_W-1:0] lowerLevel,
  output logic             rxLevelIrq
);

  // Ladder: empty, four trigger steps, full
  localparam int RUNGS = 6;
  localparam int LADDER [RUNGS] = '{0, TRIG0, TRIG1, TRIG2, TRIG3, DEPTH};

  logic [CNT_W-1:0] ladder [RUNGS];

  for (genvar g = 0; g < RUNGS; g++) begin : gRung
    assign ladder[g] = CNT_W'(LADDER[g]);
  end

  logic [2:0] selIdx;
  assign selIdx = {1'b0, trigSel};

  always_comb begin
    lowerLevel = ladder[selIdx];
    trigLevel  = ladder[selIdx + 3'd1];
    upperLevel = ladder[selIdx + 3'd2];
  end

  always_comb begin
    flags.atTrigger = (fifoCount >= trigLevel);
    flags.atUpper   = (fifoCount >= upperLevel);
    flags.atLower   = (fifoCount <= lowerLevel);
  end

  always_ff @(posedge clk) begin
    if (!rstN) rxLevelIrq <= 1'b0;
    else       rxLevelIrq <= flags.atTrigger;
  end

endmodule

// File: rtl/rts_state_ctrl.sv
module rts_state_ctrl
  import rts_pacer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  levelFlags_t flags,
  input  logic        autoRtsEn,
  input  logic        enhancedEn,
  input  logic        rtsIntEn,
  input  logic        mcrRts,
  input  logic        isrRead,
  output logic        rtsN,
  output logic        rtsIrq,
  output logic        rtsStatus
);

  rtsState_e stateQ, stateD;
  logic      riseEvt;
  logic      intArmed;

  always_comb begin
    stateD = stateQ;
    if (!autoRtsEn) begin
      stateD = mcrRts ? RTS_ACTIVE : RTS_IDLE;
    end else if (!mcrRts) begin
      stateD = RTS_IDLE;
    end else begin
      unique case (stateQ)
        RTS_IDLE:   stateD = RTS_ACTIVE;
        RTS_ACTIVE: if (flags.atUpper) stateD = RTS_PAUSED;
        RTS_PAUSED: if (flags.atLower) stateD = RTS_ACTIVE;
        default:    stateD = RTS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= RTS_IDLE;
    else       stateQ <= stateD;
  end

  assign rtsN     = (stateQ != RTS_ACTIVE);
  assign riseEvt  = (stateQ == RTS_ACTIVE) && (stateD != RTS_ACTIVE);
  assign intArmed = rtsIntEn && enhancedEn;

  always_ff @(posedge clk) begin
    if (!rstN)                    rtsStatus <= 1'b0;
    else if (riseEvt && intArmed) rtsStatus <= 1'b1;
    else if (isrRead)             rtsStatus <= 1'b0;
  end

  assign rtsIrq = rtsStatus && intArmed;

endmodule

// File: rtl/rx_rts_pacer.sv
module rx_rts_pacer
  import rts_pacer_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TRIG0 = 1,
  parameter int TRIG1 = 4,
  parameter int TRIG2 = 8,
  parameter int TRIG3 = 14,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] fifoCount,
  input  logic [1:0]       trigSel,
  input  logic             autoRtsEn,
  input  logic             enhancedEn,
  input  logic             rtsIntEn,
  input  logic             mcrRts,
  input  logic             isrRead,
  output logic             rtsN,
  output logic             rxLevelIrq,
  output logic             rtsIrq,
  output logic             rtsStatus
);

  levelFlags_t      flags;
  logic [CNT_W-1:0] trigLevel;
  logic [CNT_W-1:0] upperLevel;
  logic [CNT_W-1:0] lowerLevel;

  rts_level_cmp #(
    .DEPTH(DEPTH), .TRIG0(TRIG0), .TRIG1(TRIG1),
    .TRIG2(TRIG2), .TRIG3(TRIG3), .CNT_W(CNT_W)
  ) uLevel (
    .clk(clk), .rstN(rstN), .fifoCount(fifoCount), .trigSel(trigSel),
    .flags(flags), .trigLevel(trigLevel), .upperLevel(upperLevel),
    .lowerLevel(lowerLevel), .rxLevelIrq(rxLevelIrq)
  );

  rts_state_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .flags(flags), .autoRtsEn(autoRtsEn),
    .enhancedEn(enhancedEn), .rtsIntEn(rtsIntEn), .mcrRts(mcrRts),
    .isrRead(isrRead), .rtsN(rtsN), .rtsIrq(rtsIrq), .rtsStatus(rtsStatus)
  );

endmodule

// File: rtl/rts_pacer_chk.sv
module rts_pacer_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] fifoCount,
  input logic             autoRtsEn,
  input logic             enhancedEn,
  input logic             rtsIntEn,
  input logic             mcrRts,
  input logic             isrRead,
  input logic             rtsN,
  input logic             rxLevelIrq,
  input logic             rtsIrq,
  input logic             rtsStatus,
  input logic [CNT_W-1:0] trigLevel,
  input logic [CNT_W-1:0] upperLevel,
  input logic [CNT_W-1:0] lowerLevel
);

  logic sawResetEdge = 1'b0;
  always @(posedge clk) if (!rstN) sawResetEdge <= 1'b1;

  always @(negedge clk) begin
    if (!rstN && sawResetEdge) begin
      assert_reset_quiet_R1: assert (rtsN && !rxLevelIrq && !rtsIrq && !rtsStatus)
        else $error("R1 outputs not in reset state");
    end
  end

  assert_manual_follow_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(!autoRtsEn) |-> rtsN == !$past(mcrRts));

  assert_level_irq_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> rxLevelIrq == ($past(fifoCount) >= $past(trigLevel)));

  assert_pause_upper_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(autoRtsEn && mcrRts && !rtsN && (fifoCount >= upperLevel)) |-> rtsN);

  assert_resume_lower_R6: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(autoRtsEn && mcrRts && rtsN && (fifoCount <= lowerLevel)) |-> !rtsN);

  assert_rise_sets_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $rose(rtsN) && $past(rtsIntEn && enhancedEn) |-> rtsStatus);

  assert_no_set_masked_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && !$past(rtsIntEn && enhancedEn) && !$past(rtsStatus) |-> !rtsStatus);

  assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) && $past(isrRead) && !$rose(rtsN) |-> !rtsStatus);

  assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rstN)
    rtsIrq |-> rtsStatus && rtsIntEn && enhancedEn);

endmodule

bind rx_rts_pacer rts_pacer_chk #(.CNT_W(CNT_W)) chk (.*);

// File: tb/tb_rx_rts_pacer.sv
module tb_rx_rts_pacer;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] fifoCount = '0;
  logic [1:0] trigSel = '0;
  logic       autoRtsEn = 1'b0;
  logic       enhancedEn = 1'b0;
  logic       rtsIntEn = 1'b0;
  logic       mcrRts = 1'b0;
  logic       isrRead = 1'b0;
  logic       rtsN, rxLevelIrq, rtsIrq, rtsStatus;

  int    errors = 0;
  int    checks = 0;
  int    cycles = 0;
  bit    checking = 1'b0;
  string curTag = "R1";

  // reference model state: 0 idle, 1 active, 2 paused
  int mState = 0;
  bit mFlag = 1'b0;
  bit mRxIrq = 1'b0;

  always #2.5 clk = ~clk;

  rx_rts_pacer dut (
    .clk(clk), .rstN(rstN), .fifoCount(fifoCount), .trigSel(trigSel),
    .autoRtsEn(autoRtsEn), .enhancedEn(enhancedEn), .rtsIntEn(rtsIntEn),
    .mcrRts(mcrRts), .isrRead(isrRead), .rtsN(rtsN), .rxLevelIrq(rxLevelIrq),
    .rtsIrq(rtsIrq), .rtsStatus(rtsStatus)
  );

  function automatic int trigOf(int s);
    case (s) 0: return 1; 1: return 4; 2: return 8; default: return 14; endcase
  endfunction
  function automatic int upOf(int s);
    case (s) 0: return 4; 1: return 8; 2: return 14; default: return 16; endcase
  endfunction
  function automatic int lowOf(int s);
    case (s) 0: return 0; 1: return 1; 2: return 4; default: return 8; endcase
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mState = 0; mFlag = 0; mRxIrq = 0;
    end else begin
      int nxt;
      nxt = mState;
      if (!autoRtsEn)   nxt = mcrRts ? 1 : 0;
      else if (!mcrRts) nxt = 0;
      else if (mState == 0) nxt = 1;
      else if (mState == 1 && fifoCount >= upOf(trigSel)) nxt = 2;
      else if (mState == 2 && fifoCount <= lowOf(trigSel)) nxt = 1;
      mRxIrq = (fifoCount >= trigOf(trigSel));
      if (mState == 1 && nxt != 1 && rtsIntEn && enhancedEn) mFlag = 1;
      else if (isrRead) mFlag = 0;
      mState = nxt;
    end
  end

  task automatic cmp(string what, string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual=%b expected=%b", tag, what, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (checking) begin
      cmp("rtsN", curTag, rtsN, (mState != 1));
      cmp("rxLevelIrq", (curTag == "R1") ? "R1" : "R4", rxLevelIrq, mRxIrq);
      cmp("rtsStatus", curTag, rtsStatus, mFlag);
      cmp("rtsIrq", (curTag == "R1") ? "R1" : "R11", rtsIrq, mFlag && rtsIntEn && enhancedEn);
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic rampUp(int hi);
    for (int c = 0; c <= hi; c++) begin fifoCount = 5'(c); tick(); end
  endtask

  task automatic rampDown(int hi);
    for (int c = hi; c >= 0; c--) begin fifoCount = 5'(c); tick(); end
  endtask

  initial begin : watchdog
    #(5ns * 20000);
    errors++; checks++;
    $display("FAIL watchdog expired at cycle %0d: actual=running expected=done", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    checking = 1'b1;
    curTag = "R1";
    fifoCount = 5'd12;
    tick(3);
    rstN = 1'b1;

    // manual mode, interrupts armed
    curTag = "R2";
    enhancedEn = 1; rtsIntEn = 1;
    mcrRts = 1; tick(2);
    curTag = "R8";
    mcrRts = 0; tick(2);
    curTag = "R10";
    isrRead = 1; tick(); isrRead = 0; tick();
    curTag = "R2";
    mcrRts = 1; fifoCount = 0; tick(2);

    // automatic pacing, each trigger select
    for (int s = 0; s < 4; s++) begin
      trigSel = 2'(s);
      curTag = "R3";
      autoRtsEn = 1; mcrRts = 0; fifoCount = 0; tick(2);
      mcrRts = 1; tick(2);
      curTag = (s == 3) ? "R5" : "R7";
      rampUp(16);
      curTag = "R10";
      isrRead = 1; tick(); isrRead = 0;
      curTag = (s == 0) ? "R6" : "R7";
      rampDown(16);
      curTag = "R4";
      rampUp(upOf(s) - 1);
      rampDown(lowOf(s) + 1);
      tick();
    end

    // rise with interrupt disabled
    curTag = "R9";
    trigSel = 2'd1; fifoCount = 0; tick(2);
    rtsIntEn = 0; fifoCount = 8; tick(2);
    fifoCount = 0; tick(2);
    enhancedEn = 0; rtsIntEn = 1; fifoCount = 9; tick(2);
    fifoCount = 0; tick(2);

    // set and clear at the same edge, then mask while pending
    curTag = "R10";
    enhancedEn = 1; tick();
    fifoCount = 8; isrRead = 1; tick(); isrRead = 0; tick(2);
    curTag = "R11";
    rtsIntEn = 0; tick(2);
    rtsIntEn = 1; tick(2);
    enhancedEn = 0; tick(); enhancedEn = 1; tick();
    curTag = "R6";
    fifoCount = 1; tick(3);

    // reset while active
    curTag = "R1";
    rstN = 0; tick(2);
    rstN = 1; curTag = "R3"; tick(3);

    checking = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule